// File: doc/BRIEF.md
# Programmed-I/O Cycle Sequencer

This block runs one programmed-I/O read or write cycle on a 16-bit parallel disk bus. A host-side request names a target port (the command port or one of two device data ports), a direction, a register address and, for writes, a data word. The sequencer then drives the bus through three phases: address setup, strobe active, and recovery. Write data stays on the bus for a programmable hold window at the start of recovery. Each phase length comes from an 8-bit count, and a phase with count N lasts N+1 clocks.

Three timing sets are presented on the ports, one for each target port. Each set packs four counts, which are the setup, strobe, hold and recovery counts. Each set also has a ready-wait enable. When that enable is set, a low ready line from the device stretches the strobe phase. The set and its enable are copied at the clock that accepts the request, so a change on the timing inputs during a cycle does not affect that cycle. The register bank that feeds the sets, the bus decoding and the pad drivers sit outside this block.

The controller has four states: IDLE, SETUP, STROBE and RECOVER. The transitions are as follows:
- ACCEPT (IDLE to SETUP) happens on a request.
- ARM (SETUP to STROBE) happens when the setup count runs out.
- RELEASE (STROBE to RECOVER) happens when the strobe count has run out and ready permits it.
- FINISH (RECOVER to IDLE) happens when the recovery count runs out.

Top module: `pio_cycle_seq`

## Requirements
- R1: While reset is applied and after it is released, the outputs are idle:
  - `busy`, `ack`, `bus_cs` and `bus_doe` are low.
  - `bus_rd_n` and `bus_wr_n` are high.
  - `rdata` is zero.
- R2: A request is taken only in a clock where `req_valid` is high and `busy` is low, and `busy` is high from the next clock. A `req_valid` pulse while `busy` is high is ignored: it produces no further cycle and no further `ack`.
- R3: The setup phase lasts T1+1 clocks. During it `bus_cs` is high, `bus_addr` carries the request address, and both strobes are high. A strobe is never low unless `bus_cs` is high.
- R4: The strobe phase lasts T2+1 clocks when no ready stretch applies. During it only `bus_rd_n` is low for a read, or only `bus_wr_n` is low for a write. The two strobes are never low together.
- R5: When the selected set's ready-wait enable is 1, the strobe phase also continues for every clock whose final edge sees `bus_ready` low. With ready low for the first L strobe clocks, the phase lasts max(T2+1, L+1) clocks. When the enable is 0, `bus_ready` has no effect.
- R6: Recovery follows the strobe and lasts Teoc+1 clocks with both strobes high. One cycle therefore spans T1+T2+Teoc+3 clocks when there is no stretch. The slowest-mode counts 6/28/2/23 give 60 clocks.
- R7: For a write, `bus_doe` is high and `bus_dout` equals the request data in every clock where `bus_cs` is high. After the strobe ends, `bus_cs` stays high for min(T4, Teoc)+1 clocks. For a read, `bus_doe` stays low.
- R8: For a read, `rdata` takes `bus_din` at the edge where the strobe is negated and holds it until the next read. A write leaves `rdata` unchanged.
- R9: `ack` is high for exactly one clock, the last clock of recovery. In the next clock both `ack` and `busy` are low.
- R10: Port code 0 selects the command set, code 1 the device-0 set and code 2 the device-1 set. Code 3 also selects the command set. Bit k of `ready_wait_en` belongs to the set with code k. Each 32-bit set is packed {Teoc[31:24], T4[23:16], T2[15:8], T1[7:0]}.
- R11: The timing set and its ready-wait enable are captured when the request is accepted. A change of the timing inputs during a cycle does not alter that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request a cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_port | input | 2 | Target port code, which selects the timing set |
| req_addr | input | 3 | Register address for the bus |
| req_wdata | input | 16 | Write data |
| cmd_timing | input | 32 | Command-port timing set |
| dev0_timing | input | 32 | Device-0 data-port timing set |
| dev1_timing | input | 32 | Device-1 data-port timing set |
| ready_wait_en | input | 3 | Per-set ready-wait enables |
| busy | output | 1 | Cycle in progress |
| ack | output | 1 | One-clock completion pulse |
| rdata | output | 16 | Captured read data |
| bus_addr | output | 3 | Address to the device |
| bus_cs | output | 1 | Device select, active high |
| bus_rd_n | output | 1 | Read strobe, active low |
| bus_wr_n | output | 1 | Write strobe, active low |
| bus_doe | output | 1 | Data output enable for the pads |
| bus_dout | output | 16 | Data driven towards the device |
| bus_din | input | 16 | Data from the device |
| bus_ready | input | 1 | Device ready, low to stretch the strobe |

## Verification
The bench builds the block with its default parameters: 8-bit counts, a 16-bit data path and a 3-bit address.

At the 8-bit count width, several corners can be driven directly through the timing inputs:
- all-zero counts, where every phase lasts one clock;
- a strobe count of 255;
- the slowest-mode 60-clock cycle;
- a hold count larger than the recovery count.

The bench also holds ready low for longer than the programmed strobe, once with the wait enabled and once with it disabled. It changes a timing set mid-cycle, and it pulses a request during a busy cycle.

// File: rtl/pio_seq_pkg.sv
package pio_seq_pkg;

    // Controller states of the cycle sequencer
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_SETUP   = 2'd1,
        ST_STROBE  = 2'd2,
        ST_RECOVER = 2'd3
    } seq_state_t;

    // Number of timing counts packed into one set
    localparam int FIELDS_PER_SET = 4;

endpackage

// File: rtl/pio_down_counter.sv
module pio_down_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic [W-1:0] count,
    output logic         zero
);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (dec && (cnt_q != '0)) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign count = cnt_q;
    assign zero  = (cnt_q == '0);

endmodule

// File: rtl/pio_timing_select.sv
module pio_timing_select
    import pio_seq_pkg::*;
#(
    parameter int CNT_W    = 8,
    parameter int NUM_SETS = 3
) (
    input  logic [$clog2(NUM_SETS)-1:0]              port_code,
    input  logic [NUM_SETS*FIELDS_PER_SET*CNT_W-1:0] sets_flat,
    input  logic [NUM_SETS-1:0]                      wait_en_all,
    output logic [CNT_W-1:0]                         t_setup,
    output logic [CNT_W-1:0]                         t_strobe,
    output logic [CNT_W-1:0]                         t_hold,
    output logic [CNT_W-1:0]                         t_recover,
    output logic                                     wait_en
);

    localparam int SET_W = FIELDS_PER_SET * CNT_W;

    logic [SET_W-1:0] set_arr [NUM_SETS];
    logic [SET_W-1:0] chosen;

    // Split the flat bus into one entry per timing set
    for (genvar g = 0; g < NUM_SETS; g++) begin : g_split
        assign set_arr[g] = sets_flat[g*SET_W +: SET_W];
    end

    // Codes without a set of their own fall back to set 0 (command port)
    always_comb begin
        chosen  = set_arr[0];
        wait_en = wait_en_all[0];
        for (int k = 1; k < NUM_SETS; k++) begin
            if (int'(port_code) == k) begin
                chosen  = set_arr[k];
                wait_en = wait_en_all[k];
            end
        end
    end

    assign t_setup   = chosen[0*CNT_W +: CNT_W];
    assign t_strobe  = chosen[1*CNT_W +: CNT_W];
    assign t_hold    = chosen[2*CNT_W +: CNT_W];
    assign t_recover = chosen[3*CNT_W +: CNT_W];

endmodule

// File: rtl/pio_seq_fsm.sv
module pio_seq_fsm
    import pio_seq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    input  logic phase_zero,
    input  logic hold_zero,
    input  logic ready_ok,
    output logic accept_o,
    output logic arm_o,
    output logic release_o,
    output logic finish_o,
    output logic hold_live_o,
    output logic cs_o,
    output logic strobe_o,
    output logic busy_o
);

    seq_state_t state_q, state_d;
    logic       hold_live_q;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (req_valid)              state_d = ST_SETUP;   // ACCEPT
            ST_SETUP:   if (phase_zero)             state_d = ST_STROBE;  // ARM
            ST_STROBE:  if (phase_zero && ready_ok) state_d = ST_RECOVER; // RELEASE
            ST_RECOVER: if (phase_zero)             state_d = ST_IDLE;    // FINISH
            default:                                state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Write-hold window inside recovery
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_live_q <= 1'b0;
        end else if (release_o) begin
            hold_live_q <= 1'b1;
        end else if ((state_q == ST_RECOVER) && (hold_zero || phase_zero)) begin
            hold_live_q <= 1'b0;
        end
    end

    // Outputs decoded from the state
    always_comb begin
        accept_o  = 1'b0;
        arm_o     = 1'b0;
        release_o = 1'b0;
        finish_o  = 1'b0;
        cs_o      = 1'b0;
        strobe_o  = 1'b0;
        busy_o    = 1'b1;
        unique case (state_q)
            ST_IDLE: begin
                busy_o   = 1'b0;
                accept_o = req_valid;
            end
            ST_SETUP: begin
                cs_o  = 1'b1;
                arm_o = phase_zero;
            end
            ST_STROBE: begin
                cs_o      = 1'b1;
                strobe_o  = 1'b1;
                release_o = phase_zero && ready_ok;
            end
            ST_RECOVER: begin
                cs_o     = hold_live_q;
                finish_o = phase_zero;
            end
            default: begin
                busy_o = 1'b0;
            end
        endcase
    end

    assign hold_live_o = hold_live_q;

endmodule

// File: rtl/pio_cycle_seq.sv
module pio_cycle_seq
    import pio_seq_pkg::*;
#(
    parameter int CNT_W  = 8,
    parameter int DATA_W = 16,
    parameter int ADDR_W = 3
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          req_valid,
    input  logic                          req_write,
    input  logic [1:0]                    req_port,
    input  logic [ADDR_W-1:0]             req_addr,
    input  logic [DATA_W-1:0]             req_wdata,
    input  logic [FIELDS_PER_SET*CNT_W-1:0] cmd_timing,
    input  logic [FIELDS_PER_SET*CNT_W-1:0] dev0_timing,
    input  logic [FIELDS_PER_SET*CNT_W-1:0] dev1_timing,
    input  logic [2:0]                    ready_wait_en,
    output logic                          busy,
    output logic                          ack,
    output logic [DATA_W-1:0]             rdata,
    output logic [ADDR_W-1:0]             bus_addr,
    output logic                          bus_cs,
    output logic                          bus_rd_n,
    output logic                          bus_wr_n,
    output logic                          bus_doe,
    output logic [DATA_W-1:0]             bus_dout,
    input  logic [DATA_W-1:0]             bus_din,
    input  logic                          bus_ready
);

    localparam int NUM_SETS = 3;
    localparam int SET_W    = FIELDS_PER_SET * CNT_W;

    // Selected timing set (combinational, from the request port)
    logic [CNT_W-1:0] sel_t1, sel_t2, sel_t4, sel_teoc;
    logic             sel_wait;

    pio_timing_select #(
        .CNT_W    (CNT_W),
        .NUM_SETS (NUM_SETS)
    ) u_select (
        .port_code   (req_port),
        .sets_flat   ({dev1_timing, dev0_timing, cmd_timing}),
        .wait_en_all (ready_wait_en),
        .t_setup     (sel_t1),
        .t_strobe    (sel_t2),
        .t_hold      (sel_t4),
        .t_recover   (sel_teoc),
        .wait_en     (sel_wait)
    );

    // Values captured at acceptance
    logic [CNT_W-1:0]  lat_t2, lat_t4, lat_teoc;
    logic              lat_wait, lat_write;
    logic [ADDR_W-1:0] lat_addr;
    logic [DATA_W-1:0] lat_wdata;
    logic [DATA_W-1:0] rdata_q;

    // Sequencer control
    logic accept, arm, rel, finish, hold_live, cs, strobe, seq_busy;
    logic phase_zero, hold_zero, ready_ok;
    logic phase_load, hold_load;
    logic [CNT_W-1:0] phase_val;
    logic [CNT_W-1:0] phase_cnt, hold_cnt;

    assign ready_ok = bus_ready || !lat_wait;

    pio_seq_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .phase_zero  (phase_zero),
        .hold_zero   (hold_zero),
        .ready_ok    (ready_ok),
        .accept_o    (accept),
        .arm_o       (arm),
        .release_o   (rel),
        .finish_o    (finish),
        .hold_live_o (hold_live),
        .cs_o        (cs),
        .strobe_o    (strobe),
        .busy_o      (seq_busy)
    );

    // Phase counter: loaded at each phase entry, counts down to zero
    assign phase_load = accept || arm || rel;

    always_comb begin
        if (accept) begin
            phase_val = sel_t1;
        end else if (arm) begin
            phase_val = lat_t2;
        end else begin
            phase_val = lat_teoc;
        end
    end

    pio_down_counter #(.W(CNT_W)) u_phase_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (phase_load),
        .load_val (phase_val),
        .dec      (1'b1),
        .count    (phase_cnt),
        .zero     (phase_zero)
    );

    // Hold counter: runs from strobe release while the hold window is open
    assign hold_load = rel;

    pio_down_counter #(.W(CNT_W)) u_hold_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (hold_load),
        .load_val (lat_t4),
        .dec      (hold_live),
        .count    (hold_cnt),
        .zero     (hold_zero)
    );

    // Request capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat_t2    <= '0;
            lat_t4    <= '0;
            lat_teoc  <= '0;
            lat_wait  <= 1'b0;
            lat_write <= 1'b0;
            lat_addr  <= '0;
            lat_wdata <= '0;
        end else if (accept) begin
            lat_t2    <= sel_t2;
            lat_t4    <= sel_t4;
            lat_teoc  <= sel_teoc;
            lat_wait  <= sel_wait;
            lat_write <= req_write;
            lat_addr  <= req_addr;
            lat_wdata <= req_wdata;
        end
    end

    // Read data capture at strobe negation
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (rel && !lat_write) begin
            rdata_q <= bus_din;
        end
    end

    // Output mapping
    assign busy     = seq_busy;
    assign ack      = finish;
    assign rdata    = rdata_q;
    assign bus_addr = lat_addr;
    assign bus_cs   = cs;
    assign bus_rd_n = !(strobe && !lat_write);
    assign bus_wr_n = !(strobe && lat_write);
    assign bus_doe  = cs && lat_write;
    assign bus_dout = lat_wdata;

endmodule

// File: rtl/pio_cycle_seq_chk.sv
module pio_cycle_seq_chk #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              busy,
    input logic              ack,
    input logic [DATA_W-1:0] rdata,
    input logic              bus_cs,
    input logic              bus_rd_n,
    input logic              bus_wr_n,
    input logic              bus_doe
);

    logic stb;
    assign stb = !bus_rd_n || !bus_wr_n;

    p_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && req_valid) |=> busy);

    p_no_spurious_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !req_valid) |=> !busy);

    p_strobe_in_cs_r3: assert property (@(posedge clk) disable iff (!rst_n)
        stb |-> bus_cs);

    p_setup_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stb) |-> $past(bus_cs));

    p_cs_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        bus_cs |-> busy);

    p_one_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(!bus_rd_n && !bus_wr_n));

    p_doe_in_cs_r7: assert property (@(posedge clk) disable iff (!rst_n)
        bus_doe |-> bus_cs);

    p_rdata_on_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rdata) |-> (!$past(bus_rd_n) && bus_rd_n));

    p_ack_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ack |-> (busy && !stb));

    p_ack_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> (!ack && !busy));

endmodule

bind pio_cycle_seq pio_cycle_seq_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .busy      (busy),
    .ack       (ack),
    .rdata     (rdata),
    .bus_cs    (bus_cs),
    .bus_rd_n  (bus_rd_n),
    .bus_wr_n  (bus_wr_n),
    .bus_doe   (bus_doe)
);

// File: tb/pio_cycle_seq_tb.sv
module pio_cycle_seq_tb;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [1:0]  req_port = '0;
    logic [2:0]  req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [31:0] cmd_timing = '0;
    logic [31:0] dev0_timing = '0;
    logic [31:0] dev1_timing = '0;
    logic [2:0]  ready_wait_en = '0;
    logic        busy, ack;
    logic [15:0] rdata;
    logic [2:0]  bus_addr;
    logic        bus_cs, bus_rd_n, bus_wr_n, bus_doe;
    logic [15:0] bus_dout;
    logic [15:0] bus_din = '0;
    logic        bus_ready = 1'b1;

    always #(CLK_PERIOD/2) clk = ~clk;

    pio_cycle_seq u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (req_valid),
        .req_write     (req_write),
        .req_port      (req_port),
        .req_addr      (req_addr),
        .req_wdata     (req_wdata),
        .cmd_timing    (cmd_timing),
        .dev0_timing   (dev0_timing),
        .dev1_timing   (dev1_timing),
        .ready_wait_en (ready_wait_en),
        .busy          (busy),
        .ack           (ack),
        .rdata         (rdata),
        .bus_addr      (bus_addr),
        .bus_cs        (bus_cs),
        .bus_rd_n      (bus_rd_n),
        .bus_wr_n      (bus_wr_n),
        .bus_doe       (bus_doe),
        .bus_dout      (bus_dout),
        .bus_din       (bus_din),
        .bus_ready     (bus_ready)
    );

    typedef struct {
        bit          wr;
        int          setup;
        int          strobe;
        int          post;
        int          hold;
        logic [15:0] rdata;
        logic [15:0] wdata;
        logic [2:0]  addr;
    } exp_t;

    exp_t  exp_q[$];
    string note_q[$];

    int          n_chk = 0;
    int          n_fail = 0;
    logic [15:0] model_rdata = '0;
    int          stall_len = 0;
    int          stb_clk = 0;

    task automatic chk(input bit ok, input string what, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", what, act, expv);
        end
    endtask

    function automatic logic [31:0] pack(input int t1, input int t2, input int t4, input int teoc);
        return {8'(teoc), 8'(t4), 8'(t2), 8'(t1)};
    endfunction

    // Device ready model: ready low for the first stall_len strobe clocks
    always @(negedge clk) begin
        if (!bus_rd_n || !bus_wr_n) begin
            stb_clk   = stb_clk + 1;
            bus_ready = (stb_clk > stall_len);
        end else begin
            stb_clk   = 0;
            bus_ready = 1'b1;
        end
    end

    // Monitor: measure each cycle at the pins and compare with the scoreboard
    int   m_setup = 0, m_strobe = 0, m_post = 0, m_hold = 0;
    bit   m_saw_rd = 0, m_saw_wr = 0, m_bad_data = 0, m_bad_addr = 0;
    bit   prev_ack = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_ack) begin
                chk(!ack && !busy, "R9 ack/busy low after completion", int'(ack) + int'(busy), 0);
            end
            if (busy && exp_q.size() > 0) begin
                if (!bus_rd_n || !bus_wr_n) begin
                    m_strobe++;
                    if (!bus_rd_n) m_saw_rd = 1;
                    if (!bus_wr_n) m_saw_wr = 1;
                end else if (m_strobe == 0) begin
                    if (bus_cs) m_setup++;
                end else begin
                    m_post++;
                    if (bus_cs) m_hold++;
                end
                if (exp_q[0].wr) begin
                    if (bus_cs && (!bus_doe || bus_dout !== exp_q[0].wdata)) m_bad_data = 1;
                end else if (bus_doe) begin
                    m_bad_data = 1;
                end
                if (bus_cs && bus_addr !== exp_q[0].addr) m_bad_addr = 1;
            end
            if (ack) begin
                if (exp_q.size() == 0) begin
                    chk(0, "R2 completion without accepted request", 1, 0);
                end else begin
                    exp_t  e;
                    string n;
                    e = exp_q.pop_front();
                    n = note_q.pop_front();
                    chk(m_setup == e.setup, {"R3 setup clocks ", n}, m_setup, e.setup);
                    chk(!m_bad_addr, {"R3 address during select ", n}, int'(m_bad_addr), 0);
                    chk(m_strobe == e.strobe, {"R4 R5 strobe clocks ", n}, m_strobe, e.strobe);
                    chk(e.wr ? (m_saw_wr && !m_saw_rd) : (m_saw_rd && !m_saw_wr),
                        {"R4 strobe direction ", n}, int'(m_saw_wr), int'(e.wr));
                    chk(m_post == e.post, {"R6 recovery clocks ", n}, m_post, e.post);
                    chk(m_hold == e.hold, {"R7 select hold clocks ", n}, m_hold, e.hold);
                    chk(!m_bad_data, {"R7 data drive ", n}, int'(m_bad_data), 0);
                    chk(rdata === e.rdata, {"R8 read data ", n}, int'(rdata), int'(e.rdata));
                    chk(m_setup + m_strobe + m_post == e.setup + e.strobe + e.post,
                        {"R6 total cycle clocks ", n}, m_setup + m_strobe + m_post,
                        e.setup + e.strobe + e.post);
                end
                m_setup = 0; m_strobe = 0; m_post = 0; m_hold = 0;
                m_saw_rd = 0; m_saw_wr = 0; m_bad_data = 0; m_bad_addr = 0;
            end
            prev_ack = ack;
        end
    end

    // Driver: compute expected values from the requirements, then issue the request
    task automatic run_xfer(input logic [1:0] port, input bit wr, input logic [2:0] addr,
                            input logic [15:0] wd, input logic [15:0] din, input int stall,
                            input bit poke, input bit extra, input string note);
        logic [31:0] tv;
        bit          we;
        exp_t        e;
        int          t1, t2, t4, teoc;
        // R10: code 1 -> device 0, code 2 -> device 1, codes 0 and 3 -> command set
        tv = (port == 2'd1) ? dev0_timing : (port == 2'd2) ? dev1_timing : cmd_timing;
        we = (port == 2'd1) ? ready_wait_en[1] : (port == 2'd2) ? ready_wait_en[2] : ready_wait_en[0];
        t1 = int'(tv[7:0]); t2 = int'(tv[15:8]); t4 = int'(tv[23:16]); teoc = int'(tv[31:24]);
        e.wr     = wr;
        e.setup  = t1 + 1;
        e.strobe = (we && stall > t2) ? stall + 1 : t2 + 1;
        e.post   = teoc + 1;
        e.hold   = ((t4 < teoc) ? t4 : teoc) + 1;
        e.wdata  = wd;
        e.addr   = addr;
        if (!wr) model_rdata = din;
        e.rdata  = model_rdata;
        exp_q.push_back(e);
        note_q.push_back(note);
        stall_len = stall;
        bus_din   = din;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_port = port; req_addr = addr; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0; req_wdata = ~wd; req_addr = ~addr;
        if (poke) begin
            // R11: alter the active set during the cycle
            if (port == 2'd1) dev0_timing = pack(0, 0, 0, 0);
            else if (port == 2'd2) dev1_timing = pack(0, 0, 0, 0);
            else cmd_timing = pack(0, 0, 0, 0);
            ready_wait_en = ~ready_wait_en;
        end
        if (extra) begin
            @(negedge clk);
            req_valid = 1'b1; req_port = 2'd2; req_write = 1'b0;
            @(negedge clk);
            req_valid = 1'b0;
        end
        while (busy) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog (R9 completion): actual 0 expected 1");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        cmd_timing  = pack(6, 28, 2, 23);
        dev0_timing = pack(2, 3, 1, 4);
        dev1_timing = pack(3, 2, 7, 2);
        ready_wait_en = 3'b010;
        repeat (3) @(negedge clk);
        // R1: reset state while reset is held
        chk(!busy && !ack && !bus_cs && !bus_doe, "R1 controls idle in reset",
            int'(busy) + int'(ack) + int'(bus_cs) + int'(bus_doe), 0);
        chk(bus_rd_n && bus_wr_n, "R1 strobes negated in reset", int'(bus_rd_n & bus_wr_n), 1);
        chk(rdata == 16'h0, "R1 read data zero", int'(rdata), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(!busy && bus_rd_n && bus_wr_n, "R1 idle after release", int'(busy), 0);

        // R6: slowest-mode command-port read, 60 clocks
        run_xfer(2'd0, 1'b0, 3'd7, 16'h0000, 16'hA5C3, 0, 1'b0, 1'b0, "cmd slowest read");
        // R7: device-0 write
        run_xfer(2'd1, 1'b1, 3'd2, 16'h1234, 16'hFFFF, 0, 1'b0, 1'b0, "dev0 write");
        // R5: ready stretch with wait enabled
        run_xfer(2'd1, 1'b0, 3'd1, 16'h0000, 16'h0F0F, 9, 1'b0, 1'b0, "dev0 stretched read");
        // R5: ready ignored when wait disabled
        run_xfer(2'd2, 1'b0, 3'd3, 16'h0000, 16'h7E81, 9, 1'b0, 1'b0, "dev1 ready ignored");
        // R7: hold longer than recovery is cut at recovery end
        run_xfer(2'd2, 1'b1, 3'd4, 16'hC001, 16'h0000, 0, 1'b0, 1'b0, "dev1 clamped hold");
        // R10: code 3 uses the command set
        cmd_timing = pack(1, 4, 0, 5);
        run_xfer(2'd3, 1'b0, 3'd5, 16'h0000, 16'hBEEF, 0, 1'b0, 1'b0, "R10 code 3 read");
        // R11 and R2: mid-cycle timing change and ignored request while busy
        run_xfer(2'd1, 1'b1, 3'd6, 16'h55AA, 16'h0000, 0, 1'b1, 1'b1, "R11 latched set");
        repeat (4) begin
            @(negedge clk);
            chk(!busy && !ack, "R2 request during busy ignored", int'(busy), 0);
        end
        // Boundary: all counts zero (set changed by the previous poke)
        ready_wait_en = 3'b010;
        run_xfer(2'd1, 1'b0, 3'd0, 16'h0000, 16'h5555, 0, 1'b0, 1'b0, "zero counts read");
        // Boundary: strobe count 255
        dev0_timing = pack(1, 255, 0, 1);
        run_xfer(2'd1, 1'b1, 3'd3, 16'h9ABC, 16'h0000, 0, 1'b0, 1'b0, "max strobe write");

        repeat (5) @(negedge clk);
        chk(exp_q.size() == 0, "R9 every request completed", exp_q.size(), 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule